// File: doc/BRIEF.md
# Two-Frame Slip Buffer

This block carries a byte stream from a line clock domain into a system clock domain through a store that holds two complete frames of 32 byte slots each. The line side writes one byte per enabled write cycle. A start-of-frame marker on the first byte of each frame puts that byte in slot 0. The system side pulls one byte per enabled read cycle and gets a marker with every byte that came from slot 0.

The two clocks are not tied together, so over time the reader drifts towards or away from the writer. At the start of every read frame the block measures the separation between the write and read pointers. If the reader is about to catch the writer, or the writer is about to lap the reader, the block moves the read pointer by one whole frame. One frame is then repeated or dropped, and no byte is ever torn inside a frame. A separate sticky flag records each kind of slip until the system side clears it.

Top module: `elastic_store`

## Requirements
- R1: After reset, rd_data is 0, rd_sof is 0, and both slip flags are 0. The read pointer starts one frame (32 slots) behind the write pointer: after reset, the write pointer is at slot 0 of frame 0 and the read pointer is at slot 0 of frame 1.
- R2: Each write cycle with wr_en=1 and wr_sof=0 stores wr_data at the write pointer and advances the pointer by one. The pointer wraps from 63 to 0.
- R3: A write with wr_sof=1 stores its byte in slot 0. If the write pointer is not already at a slot-0 position, the byte goes to slot 0 of the next frame. Otherwise it goes to the current position. The pointer then continues from slot 1.
- R4: A read cycle with rd_en=1 presents the addressed byte on rd_data after the next rising rd_clk edge. rd_sof is 1 exactly when that byte came from slot 0.
- R5: The slip decision is made only on a read cycle whose read pointer sits at slot 0. It uses the separation (synchronized write pointer minus read pointer, modulo 64). Inside a frame the read pointer always advances by exactly one.
- R6: If the separation at a read frame start is below 4, the read pointer moves back one frame before the read, so the previous frame is repeated, and repeat_flag becomes 1.
- R7: If the separation at a read frame start is above 60, the read pointer moves forward one frame before the read, so one frame is dropped, and drop_flag becomes 1.
- R8: Each slip flag stays 1 until its clear input is 1 on a read clock edge. If a slip and a clear of the same flag coincide, the flag ends up 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Line-side clock |
| rd_clk | input | 1 | System-side clock |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| wr_en | input | 1 | Write one byte this wr_clk cycle |
| wr_sof | input | 1 | Byte being written is the first of a frame |
| wr_data | input | 8 | Byte to write |
| rd_en | input | 1 | Read one byte this rd_clk cycle |
| rd_data | output | 8 | Byte read, registered |
| rd_sof | output | 1 | rd_data came from slot 0 |
| drop_clr | input | 1 | Clear drop_flag (rd_clk domain) |
| repeat_clr | input | 1 | Clear repeat_flag (rd_clk domain) |
| drop_flag | output | 1 | Sticky: a frame was skipped |
| repeat_flag | output | 1 | Sticky: a frame was read twice |

## Verification
A byte read appears on rd_data and rd_sof one rd_clk edge after rd_en is accepted. A slip flag changes on the same edge that reads the frame's first byte. The bench drives every input on a falling edge and samples on the following falling edge, so each result is read half a cycle after the edge that makes it. A write reaches the slip decision only after the gray pointer register and two synchronizer flops, at most about three read cycles later. After each burst of writes, the bench therefore idles eight read cycles before reading, which makes every separation exact. Flags are read after the whole 32-byte frame, when the frame-start edge has long passed.

// File: rtl/es_pkg.sv
package es_pkg;
    // Outcome of the slip decision at a read frame start
    typedef enum logic [1:0] {
        SLIP_NONE   = 2'd0,
        SLIP_REPEAT = 2'd1,
        SLIP_DROP   = 2'd2
    } slip_kind_e;
endpackage

// File: rtl/es_wr_ctrl.sv
module es_wr_ctrl #(
    parameter int SLOT_W  = 5,
    parameter int FRAME_W = 1,
    localparam int AW     = SLOT_W + FRAME_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          wr_sof,
    output logic [AW-1:0] wr_addr,
    output logic [AW-1:0] wgray
);
    typedef struct packed {
        logic [AW-1:0] wptr;
        logic [AW-1:0] gray;
    } wr_state_t;

    wr_state_t st_d, st_q;
    logic [AW-1:0] addr_eff;
    logic [FRAME_W-1:0] next_frame;

    always_comb begin
        st_d       = st_q;
        next_frame = st_q.wptr[AW-1:SLOT_W] + 1'b1;
        if (wr_sof && (st_q.wptr[SLOT_W-1:0] != '0))
            addr_eff = {next_frame, {SLOT_W{1'b0}}};
        else
            addr_eff = st_q.wptr;
        if (wr_en)
            st_d.wptr = addr_eff + 1'b1;
        st_d.gray = st_d.wptr ^ (st_d.wptr >> 1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wr_addr = addr_eff;
    assign wgray   = st_q.gray;

    // R2
    wr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_sof) |=> (st_q.wptr == $past(st_q.wptr) + 1'b1));
    // R3
    wr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sof) |=> (st_q.wptr[SLOT_W-1:0] == {{(SLOT_W-1){1'b0}}, 1'b1}));
endmodule

// File: rtl/es_gray_sync.sv
module es_gray_sync #(
    parameter int WIDTH  = 6,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stage_d [STAGES];
    logic [WIDTH-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = din;
        for (int s = 1; s < STAGES; s++)
            stage_d[s] = stage_q[s-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= stage_d[s];
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/es_rd_ctrl.sv
module es_rd_ctrl
    import es_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int SLOT_W  = 5,
    parameter int FRAME_W = 1,
    parameter int MARGIN  = 4,
    localparam int AW     = SLOT_W + FRAME_W,
    localparam int DEPTH  = 1 << AW,
    localparam int FRAME  = 1 << SLOT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [AW-1:0]     wgray_sync,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              drop_clr,
    input  logic              repeat_clr,
    output logic [AW-1:0]     rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_sof,
    output logic              drop_flag,
    output logic              repeat_flag
);
    localparam logic [AW-1:0] FRAME_V = FRAME[AW-1:0];
    localparam logic [AW-1:0] LOW_V   = MARGIN[AW-1:0];
    localparam logic [AW-1:0] HIGH_V  = (DEPTH - MARGIN);
    localparam logic [AW-1:0] RST_PTR = (DEPTH - FRAME);

    typedef struct packed {
        logic [AW-1:0]     rptr;
        logic [DATA_W-1:0] data;
        logic              sof;
        logic              drop;
        logic              rep;
    } rd_state_t;

    rd_state_t  st_d, st_q;
    logic [AW-1:0] wbin;
    logic [AW-1:0] sep;
    logic [AW-1:0] addr_eff;
    slip_kind_e kind;

    always_comb begin
        wbin[AW-1] = wgray_sync[AW-1];
        for (int b = AW - 2; b >= 0; b--)
            wbin[b] = wbin[b+1] ^ wgray_sync[b];
    end

    always_comb begin
        st_d = st_q;
        sep  = wbin - st_q.rptr;
        kind = SLIP_NONE;
        if (rd_en && (st_q.rptr[SLOT_W-1:0] == '0)) begin
            if (sep < LOW_V)       kind = SLIP_REPEAT;
            else if (sep > HIGH_V) kind = SLIP_DROP;
        end
        case (kind)
            SLIP_REPEAT: addr_eff = st_q.rptr - FRAME_V;
            SLIP_DROP:   addr_eff = st_q.rptr + FRAME_V;
            default:     addr_eff = st_q.rptr;
        endcase
        if (rd_en) begin
            st_d.rptr = addr_eff + 1'b1;
            st_d.data = mem_rdata;
            st_d.sof  = (addr_eff[SLOT_W-1:0] == '0);
        end else begin
            st_d.sof  = 1'b0;
        end
        st_d.drop = (st_q.drop && !drop_clr)   || (kind == SLIP_DROP);
        st_d.rep  = (st_q.rep  && !repeat_clr) || (kind == SLIP_REPEAT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.rptr <= RST_PTR;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_addr     = addr_eff;
    assign rd_data     = st_q.data;
    assign rd_sof      = st_q.sof;
    assign drop_flag   = st_q.drop;
    assign repeat_flag = st_q.rep;

    // R5
    rd_in_frame_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (st_q.rptr[SLOT_W-1:0] != '0)) |=> (st_q.rptr == $past(st_q.rptr) + 1'b1));
    // R4
    rd_sof_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_sof |-> $past(rd_en));
    // R6
    rep_rise_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(repeat_flag) |-> ($past(rd_en) && rd_sof));
    // R7
    drop_rise_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drop_flag) |-> ($past(rd_en) && rd_sof));
    // R8
    drop_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_flag && !drop_clr) |=> drop_flag);
    // R8
    rep_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (repeat_flag && !repeat_clr) |=> repeat_flag);
endmodule

// File: rtl/elastic_store.sv
module elastic_store #(
    parameter int DATA_W  = 8,
    parameter int SLOT_W  = 5,
    parameter int FRAME_W = 1,
    parameter int MARGIN  = 4,
    parameter int SYNC_N  = 2,
    localparam int AW     = SLOT_W + FRAME_W,
    localparam int DEPTH  = 1 << AW
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sof,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_sof,
    input  logic              drop_clr,
    input  logic              repeat_clr,
    output logic              drop_flag,
    output logic              repeat_flag
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_addr;
    logic [AW-1:0]     wgray;
    logic [AW-1:0]     wgray_sync;
    logic [AW-1:0]     rd_addr;
    logic [DATA_W-1:0] mem_rdata;

    es_wr_ctrl #(.SLOT_W(SLOT_W), .FRAME_W(FRAME_W)) wr_ctrl_i (
        .clk     (wr_clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sof  (wr_sof),
        .wr_addr (wr_addr),
        .wgray   (wgray)
    );

    always_ff @(posedge wr_clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    es_gray_sync #(.WIDTH(AW), .STAGES(SYNC_N)) sync_i (
        .clk   (rd_clk),
        .rst_n (rst_n),
        .din   (wgray),
        .dout  (wgray_sync)
    );

    assign mem_rdata = mem[rd_addr];

    es_rd_ctrl #(
        .DATA_W (DATA_W),
        .SLOT_W (SLOT_W),
        .FRAME_W(FRAME_W),
        .MARGIN (MARGIN)
    ) rd_ctrl_i (
        .clk         (rd_clk),
        .rst_n       (rst_n),
        .rd_en       (rd_en),
        .wgray_sync  (wgray_sync),
        .mem_rdata   (mem_rdata),
        .drop_clr    (drop_clr),
        .repeat_clr  (repeat_clr),
        .rd_addr     (rd_addr),
        .rd_data     (rd_data),
        .rd_sof      (rd_sof),
        .drop_flag   (drop_flag),
        .repeat_flag (repeat_flag)
    );
endmodule

// File: tb/elastic_store_tb.sv
module elastic_store_tb_top;
    logic wr_clk = 1'b0;
    logic rd_clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0, wr_sof = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic rd_en = 1'b0;
    logic [7:0] rd_data;
    logic rd_sof;
    logic drop_clr = 1'b0, repeat_clr = 1'b0;
    logic drop_flag, repeat_flag;

    int checks = 0;
    int errors = 0;

    always #4 rd_clk = ~rd_clk;   // 125 MHz system clock
    always #5 wr_clk = ~wr_clk;   // line clock

    elastic_store dut_i (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_sof(wr_sof), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .rd_sof(rd_sof),
        .drop_clr(drop_clr), .repeat_clr(repeat_clr),
        .drop_flag(drop_flag), .repeat_flag(repeat_flag)
    );

    localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_CR = 2'd2, OP_CD = 2'd3;

    typedef struct packed {
        logic [1:0] op;
        logic [2:0] tag;
        logic [5:0] cnt;
        logic       exp_drop;
        logic       exp_rep;
    } vec_t;

    localparam int NVEC = 13;
    localparam vec_t VEC [NVEC] = '{
        '{OP_WR, 3'd1, 6'd32, 1'b0, 1'b0},
        '{OP_WR, 3'd2, 6'd32, 1'b0, 1'b0},
        '{OP_RD, 3'd2, 6'd32, 1'b0, 1'b0},  // R1 start one frame behind, R2 wrap
        '{OP_RD, 3'd2, 6'd32, 1'b0, 1'b1},  // R6 repeat
        '{OP_CR, 3'd0, 6'd0,  1'b0, 1'b0},  // R8 clear
        '{OP_WR, 3'd3, 6'd32, 1'b0, 1'b0},
        '{OP_RD, 3'd3, 6'd32, 1'b0, 1'b0},
        '{OP_WR, 3'd4, 6'd32, 1'b0, 1'b0},
        '{OP_WR, 3'd5, 6'd30, 1'b0, 1'b0},
        '{OP_RD, 3'd5, 6'd30, 1'b1, 1'b0},  // R7 drop
        '{OP_WR, 3'd6, 6'd32, 1'b1, 1'b0},  // R3 realign from slot 30
        '{OP_RD, 3'd6, 6'd32, 1'b1, 1'b0},
        '{OP_CD, 3'd0, 6'd0,  1'b0, 1'b0}   // R8 clear
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (8) @(negedge rd_clk);
    endtask

    task automatic write_frame(input logic [2:0] tag, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge wr_clk);
            wr_en   = 1'b1;
            wr_sof  = (i == 0);
            wr_data = {tag, i[4:0]};
        end
        @(negedge wr_clk);
        wr_en  = 1'b0;
        wr_sof = 1'b0;
        settle();
    endtask

    task automatic read_frame(input logic [2:0] tag, input int n, input bit clr_first);
        int bad_data = 0;
        int bad_sof = 0;
        @(negedge rd_clk);
        rd_en = 1'b1;
        repeat_clr = clr_first;
        for (int i = 0; i < 32; i++) begin
            @(negedge rd_clk);
            repeat_clr = 1'b0;
            if (i == 31) rd_en = 1'b0;
            if (rd_sof !== (i == 0)) bad_sof++;
            if (i < n && rd_data !== {tag, i[4:0]}) bad_data++;
        end
        chk(bad_data == 0, "R4/R5 frame content", bad_data, 0);
        chk(bad_sof == 0, "R4 sof marker", bad_sof, 0);
        settle();
    endtask

    initial begin
        #(200000 * 8);
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge rd_clk);
        rst_n = 1'b1;
        repeat (2) @(negedge rd_clk);
        // R1 reset state
        chk(rd_data == 8'h00, "R1 rd_data", rd_data, 0);
        chk(rd_sof == 1'b0, "R1 rd_sof", rd_sof, 0);
        chk(drop_flag == 1'b0, "R1 drop_flag", drop_flag, 0);
        chk(repeat_flag == 1'b0, "R1 repeat_flag", repeat_flag, 0);

        for (int v = 0; v < NVEC; v++) begin
            case (VEC[v].op)
                OP_WR: write_frame(VEC[v].tag, int'(VEC[v].cnt));
                OP_RD: read_frame(VEC[v].tag, int'(VEC[v].cnt), 1'b0);
                OP_CR: begin
                    @(negedge rd_clk); repeat_clr = 1'b1;
                    @(negedge rd_clk); repeat_clr = 1'b0;
                    @(negedge rd_clk);
                end
                default: begin
                    @(negedge rd_clk); drop_clr = 1'b1;
                    @(negedge rd_clk); drop_clr = 1'b0;
                    @(negedge rd_clk);
                end
            endcase
            if (VEC[v].op != OP_WR) begin
                chk(drop_flag == VEC[v].exp_drop, "R7/R8 drop_flag", drop_flag, VEC[v].exp_drop);
                chk(repeat_flag == VEC[v].exp_rep, "R6/R8 repeat_flag", repeat_flag, VEC[v].exp_rep);
            end
        end

        // R8: clear coinciding with a repeat slip leaves the flag set
        read_frame(3'd6, 32, 1'b1);
        chk(repeat_flag == 1'b1, "R8 set wins over clear", repeat_flag, 1);
        chk(drop_flag == 1'b0, "R8 drop stays clear", drop_flag, 0);

        // R1: reset mid-run clears flags and outputs
        @(negedge rd_clk); rst_n = 1'b0;
        @(negedge rd_clk);
        chk(repeat_flag == 1'b0, "R1 flags after reset", repeat_flag, 0);
        chk(rd_data == 8'h00, "R1 rd_data after reset", rd_data, 0);
        rst_n = 1'b1;
        settle();

        // R1/R2 after reset: two frames written, first read returns the second
        write_frame(3'd7, 32);
        write_frame(3'd3, 32);
        read_frame(3'd3, 32, 1'b0);
        chk(repeat_flag == 1'b0 && drop_flag == 1'b0, "R1 no slip after reset", {drop_flag, repeat_flag}, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule